// File: doc/BRIEF.md
# Weighted Dominant-Input Majority Gate

This block models a three-input majority-style node built from nanomagnet-like cells. Two vertical inputs couple weakly to a center node and count at half weight. A single horizontal input couples strongly, acts with inverting sense, and dominates. Each input is a three-valued level: null, logic 0 or logic 1. The three inputs may become defined in different cycles, and the arrival order is supplied by whatever drives the pins.

The center node evaluates a weighted sum every cycle while it is still null. It latches the first defined result it reaches and holds it until a zone-clock reset phase erases it. The registered output follows the center one cycle later. A second mode reuses the same sum with one term tied to logic 0, which makes a lazy AND of the two vertical inputs: it can only produce 0 or null.

The inputs are plain levels, not a stream. The defined bit of each code plays the part of a valid flag. No ready flag exists because the node never refuses or stalls an input.

Top module: `dmaj_gate`

## Requirements
- R1: After `rst_n` is low, `out_state` reads null and the gate is in dominant-input mode until a zone reset loads another mode. Codes are 2'b00 null, 2'b10 logic 0 and 2'b11 logic 1, and the code 2'b01 is read as null.
- R2: In dominant-input mode the doubled magnetization is M = a + b - 2h, where each term is +1 for logic 1, -1 for logic 0 and 0 for null, with a and b the vertical inputs and h the horizontal input. M below -1 gives 0, M above +1 gives 1, and M from -1 to +1 gives null.
- R3: In dominant-input mode, while the horizontal input is null, a single defined vertical input or two vertical inputs that disagree leave the center null.
- R4: Once the center holds 0 or 1, later changes on any input, including a late horizontal input, do not alter it until the next zone reset.
- R5: In lazy mode M = 2a + 2b - 2, ignoring the horizontal input. M below 0 gives 0 and any other M gives null, so the output is never 1.
- R6: In lazy mode the final result does not depend on which vertical input arrives first.
- R7: A cycle with `zone_reset` high forces both the center and `out_state` to null at that clock edge.
- R8: `mode_lazy` is captured only on edges where `zone_reset` is high (1 = lazy, 0 = dominant-input). At all other times its value has no effect.
- R9: Inputs present before rising edge k decide the center at edge k, and `out_state` shows that value from edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zone_reset | input | 1 | Zone clock reset phase; clears the node and samples the mode |
| mode_lazy | input | 1 | Mode request: 1 lazy AND, 0 dominant-input |
| vert_a | input | 2 | First weak vertical input, three-valued code |
| vert_b | input | 2 | Second weak vertical input, three-valued code |
| horiz | input | 2 | Dominant horizontal input, three-valued code |
| out_state | output | 2 | Resolved node value, three-valued code |

## Verification
The bench aims at arrival-order races. In one case an agreeing vertical pair arrives before an opposing horizontal input, and a design that keeps re-evaluating would flip its output when the late input lands. Lone or disagreeing vertical inputs are driven to confirm that the null band is inclusive, since a design with an exclusive bound would resolve them too early. Lazy mode is exercised with both arrival orders and with the horizontal pin held at logic 0, so a design that counts that pin or emits a 1 is exposed. The mode pin is toggled outside reset phases to show that a design sampling it at any time would switch behaviour partway through an evaluation.

// File: rtl/dmaj_pkg.sv
package dmaj_pkg;
  // Three-valued cell codes: bit 1 marks a defined level, bit 0 carries it.
  localparam logic [1:0] CODE_NULL = 2'b00;
  localparam logic [1:0] CODE_ZERO = 2'b10;
  localparam logic [1:0] CODE_ONE  = 2'b11;

  typedef enum logic {
    MODE_DOMINANT = 1'b0,
    MODE_LAZY     = 1'b1
  } gate_mode_e;

  // Signed polarity of a code: +1 for one, -1 for zero, 0 for anything null.
  function automatic logic signed [1:0] polarity(input logic [1:0] code);
    case (code)
      CODE_ONE:  polarity = 2'sb01;
      CODE_ZERO: polarity = 2'sb11;
      default:   polarity = 2'sb00;
    endcase
  endfunction
endpackage

// File: rtl/dmaj_weigh.sv
module dmaj_weigh
  import dmaj_pkg::*;
#(
  parameter int MAG_W    = 4,
  parameter int VERT_WT  = 1,
  parameter int HORIZ_WT = 2,
  parameter int LAZY_WT  = 2
) (
  input  logic [1:0]              vert_a,
  input  logic [1:0]              vert_b,
  input  logic [1:0]              horiz,
  input  gate_mode_e              mode,
  output logic signed [MAG_W-1:0] mag
);
  localparam int N_IN = 3;
  localparam logic signed [MAG_W-1:0] VW = MAG_W'(VERT_WT);
  localparam logic signed [MAG_W-1:0] HW = MAG_W'(HORIZ_WT);
  localparam logic signed [MAG_W-1:0] LW = MAG_W'(LAZY_WT);

  logic [N_IN-1:0][1:0]    codes;
  logic signed [MAG_W-1:0] pol [N_IN];

  assign codes = {horiz, vert_b, vert_a};

  for (genvar i = 0; i < N_IN; i++) begin : g_pol
    assign pol[i] = MAG_W'(polarity(codes[i]));
  end

  always_comb begin
    if (mode == MODE_LAZY) begin
      // One leg tied to logic 0 contributes a fixed negative term.
      mag = LW * pol[0] + LW * pol[1] - LW;
    end else begin
      // Horizontal coupling is antiparallel, hence the subtraction.
      mag = VW * pol[0] + VW * pol[1] - HW * pol[2];
    end
  end
endmodule

// File: rtl/dmaj_resolve.sv
module dmaj_resolve
  import dmaj_pkg::*;
#(
  parameter int MAG_W   = 4,
  parameter int DICT_TH = 1
) (
  input  logic signed [MAG_W-1:0] mag,
  input  gate_mode_e              mode,
  output logic [1:0]              decided
);
  localparam logic signed [MAG_W-1:0] TH_POS = MAG_W'(DICT_TH);
  localparam logic signed [MAG_W-1:0] TH_NEG = -TH_POS;
  localparam logic signed [MAG_W-1:0] ZERO_M = '0;

  always_comb begin
    decided = CODE_NULL;
    if (mode == MODE_LAZY) begin
      if (mag < ZERO_M) decided = CODE_ZERO;
    end else begin
      if (mag < TH_NEG)      decided = CODE_ZERO;
      else if (mag > TH_POS) decided = CODE_ONE;
    end
  end
endmodule

// File: rtl/dmaj_hold.sv
module dmaj_hold
  import dmaj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zone_reset,
  input  logic [1:0] decided,
  output logic [1:0] center_q,
  output logic [1:0] out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      center_q <= CODE_NULL;
      out_q    <= CODE_NULL;
    end else if (zone_reset) begin
      center_q <= CODE_NULL;
      out_q    <= CODE_NULL;
    end else begin
      if (center_q == CODE_NULL) center_q <= decided;
      out_q <= center_q;
    end
  end
endmodule

// File: rtl/dmaj_gate.sv
module dmaj_gate
  import dmaj_pkg::*;
#(
  parameter int MAG_W    = 4,
  parameter int VERT_WT  = 1,
  parameter int HORIZ_WT = 2,
  parameter int LAZY_WT  = 2,
  parameter int DICT_TH  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zone_reset,
  input  logic       mode_lazy,
  input  logic [1:0] vert_a,
  input  logic [1:0] vert_b,
  input  logic [1:0] horiz,
  output logic [1:0] out_state
);
  gate_mode_e              mode_q;
  logic signed [MAG_W-1:0] mag;
  logic [1:0]              decided;
  logic [1:0]              center_q;

  // Mode is latched only during the reset phase of the zone clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= MODE_DOMINANT;
    else if (zone_reset) mode_q <= mode_lazy ? MODE_LAZY : MODE_DOMINANT;
  end

  dmaj_weigh #(
    .MAG_W(MAG_W), .VERT_WT(VERT_WT), .HORIZ_WT(HORIZ_WT), .LAZY_WT(LAZY_WT)
  ) u_weigh (
    .vert_a(vert_a), .vert_b(vert_b), .horiz(horiz), .mode(mode_q), .mag(mag)
  );

  dmaj_resolve #(.MAG_W(MAG_W), .DICT_TH(DICT_TH)) u_resolve (
    .mag(mag), .mode(mode_q), .decided(decided)
  );

  dmaj_hold u_hold (
    .clk(clk), .rst_n(rst_n), .zone_reset(zone_reset),
    .decided(decided), .center_q(center_q), .out_q(out_state)
  );
endmodule

// File: rtl/dmaj_gate_chk.sv
module dmaj_gate_chk
  import dmaj_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       zone_reset,
  input logic [1:0] vert_a,
  input logic [1:0] vert_b,
  input logic [1:0] horiz,
  input gate_mode_e mode_q,
  input logic [1:0] center_q,
  input logic [1:0] out_state
);
  assert_zone_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zone_reset |=> (out_state == CODE_NULL && center_q == CODE_NULL));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_state != CODE_NULL && !zone_reset) |=> (out_state == $past(out_state)));

  assert_lazy_no_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LAZY) |-> (out_state != CODE_ONE));

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !zone_reset |=> $stable(mode_q));

  assert_lone_vertical_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DOMINANT && !horiz[1] && (vert_a[1] ^ vert_b[1])
     && center_q == CODE_NULL && !zone_reset) |=> (center_q == CODE_NULL));
endmodule

bind dmaj_gate dmaj_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .zone_reset(zone_reset),
  .vert_a(vert_a), .vert_b(vert_b), .horiz(horiz),
  .mode_q(mode_q), .center_q(center_q), .out_state(out_state)
);

// File: tb/test_dmaj_gate.sv
module test_dmaj_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] NUL = 2'b00;
  localparam logic [1:0] ZRO = 2'b10;
  localparam logic [1:0] ONE = 2'b11;
  localparam logic [1:0] BAD = 2'b01;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zone_reset = 1'b0;
  logic       mode_lazy = 1'b0;
  logic [1:0] vert_a = NUL;
  logic [1:0] vert_b = NUL;
  logic [1:0] horiz = NUL;
  logic [1:0] out_state;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [1:0] m_center = NUL;
  logic [1:0] m_out = NUL;
  logic       m_lazy = 1'b0;

  dmaj_gate i_dmaj_gate (
    .clk(clk), .rst_n(rst_n), .zone_reset(zone_reset), .mode_lazy(mode_lazy),
    .vert_a(vert_a), .vert_b(vert_b), .horiz(horiz), .out_state(out_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pol(input logic [1:0] c);
    if (c == ONE) return 1;
    if (c == ZRO) return -1;
    return 0;
  endfunction

  // Expected decision from the requirement formulas (R2, R5).
  function automatic logic [1:0] decide(input logic lazy, input logic [1:0] a,
                                        input logic [1:0] b, input logic [1:0] h);
    int m;
    if (lazy) begin
      m = 2*pol(a) + 2*pol(b) - 2;
      return (m < 0) ? ZRO : NUL;
    end
    m = pol(a) + pol(b) - 2*pol(h);
    if (m < -1) return ZRO;
    if (m > 1)  return ONE;
    return NUL;
  endfunction

  function automatic logic [1:0] rcode();
    case ($urandom % 4)
      0: return NUL;
      1: return ZRO;
      2: return ONE;
      default: return BAD;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out_state=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: update the model at the edge, compare at the falling edge.
  task automatic cycle(input string req);
    @(posedge clk);
    if (!rst_n) begin
      m_center = NUL; m_out = NUL; m_lazy = 1'b0;
    end else if (zone_reset) begin
      m_center = NUL; m_out = NUL; m_lazy = mode_lazy;
    end else begin
      m_out = m_center;
      if (m_center == NUL) m_center = decide(m_lazy, vert_a, vert_b, horiz);
    end
    @(negedge clk);
    check(req, out_state, m_out);
  endtask

  task automatic zreset(input logic lazy);
    vert_a = NUL; vert_b = NUL; horiz = NUL;
    zone_reset = 1'b1; mode_lazy = lazy;
    cycle("R7");
    zone_reset = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd731));
    // R1: reset state.
    cycle("R1");
    check("R1", out_state, NUL);
    @(negedge clk); rst_n = 1'b1;
    // R1: default mode is dominant-input, so an agreeing pair gives 1.
    vert_a = ONE; vert_b = ONE;
    cycle("R9");
    check("R9", out_state, NUL);
    cycle("R1");
    check("R1", out_state, ONE);

    // R4: agreeing zero pair first, then an opposing horizontal zero.
    zreset(1'b0);
    vert_a = ZRO; vert_b = ZRO;
    cycle("R2"); cycle("R2");
    check("R2", out_state, ZRO);
    horiz = ZRO;
    cycle("R4"); cycle("R4");
    check("R4", out_state, ZRO);

    // R3: lone vertical, then disagreeing pair, stay null; horizontal decides.
    zreset(1'b0);
    vert_a = ONE;
    cycle("R3"); cycle("R3");
    check("R3", out_state, NUL);
    vert_b = ZRO;
    cycle("R3"); cycle("R3");
    check("R3", out_state, NUL);
    horiz = ZRO;
    cycle("R2"); cycle("R2");
    check("R2", out_state, ONE);

    // R2: null band is inclusive: lone vertical 1 against horizontal 1 stays null.
    zreset(1'b0);
    vert_a = ONE; horiz = ONE;
    cycle("R2"); cycle("R2");
    check("R2", out_state, NUL);

    // R5: lazy mode never emits 1 and ignores the horizontal input.
    zreset(1'b1);
    vert_a = ONE; vert_b = ONE; horiz = ZRO;
    cycle("R5"); cycle("R5");
    check("R5", out_state, NUL);
    zreset(1'b1);
    vert_a = ZRO; horiz = ONE;
    cycle("R5"); cycle("R5");
    check("R5", out_state, ZRO);

    // R6: lazy result independent of arrival order.
    zreset(1'b1);
    vert_b = ONE; cycle("R6"); cycle("R6");
    vert_a = ZRO; cycle("R6"); cycle("R6");
    check("R6", out_state, ZRO);
    zreset(1'b1);
    vert_a = ZRO; cycle("R6"); cycle("R6");
    vert_b = ONE; cycle("R6"); cycle("R6");
    check("R6", out_state, ZRO);

    // R8: mode pin toggled outside a reset phase has no effect.
    zreset(1'b0);
    mode_lazy = 1'b1;
    vert_a = ONE; vert_b = ONE;
    cycle("R8"); cycle("R8");
    check("R8", out_state, ONE);

    // R7: reset phase clears a settled output.
    zone_reset = 1'b1; mode_lazy = 1'b0;
    cycle("R7");
    check("R7", out_state, NUL);
    zone_reset = 1'b0;

    // Random arrival orders, checked every cycle against the model (R2 R4 R5 R9).
    for (int t = 0; t < 400; t++) begin
      logic [1:0] ta, tb, th;
      int aa, ab, ah;
      zreset(1'($urandom % 2));
      ta = rcode(); tb = rcode(); th = rcode();
      aa = $urandom % 5; ab = $urandom % 5; ah = $urandom % 5;
      for (int c = 0; c < 8; c++) begin
        if (c == 6) begin ta = rcode(); tb = rcode(); th = rcode(); end
        vert_a = (c >= aa) ? ta : NUL;
        vert_b = (c >= ab) ? tb : NUL;
        horiz  = (c >= ah) ? th : NUL;
        mode_lazy = 1'($urandom % 2);
        cycle("R4");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule